// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock With Alarm

This block keeps wall-clock time as a 32-bit count of seconds. A 32-bit divisor word, which software sets to the reference clock rate in Hz, turns the reference clock into one tick per second. Software reaches the block through a simple single-cycle register port with 16-bit data. Every 32-bit quantity is split across a low and a high register.

Software never touches the live counter directly. To set the time, it writes a 32-bit preset value and then raises a load request bit. To read the time, it raises a snapshot request bit. In both cases the hardware clears the request bit itself once the transfer is done, so software polls for the bit to drop.

A 32-bit alarm value is compared with the counter each time the counter takes a new value. On a match the block sets a sticky alarm flag. The flag drives an interrupt line through a mask. Software can also force the flag or clear it with pulse bits in the control register.

Top module: `rtc_seconds`

## Requirements
- R1: After reset every register reads 0, the interrupt output is 0 and the counter is stopped.
- R2: Byte offsets are 0x00 control, 0x04/0x08 divisor low/high, 0x0C/0x10 preset low/high, 0x14/0x18 alarm low/high, 0x1C status, 0x20/0x24 snapshot low/high. Divisor, preset and alarm read back as written. Unmapped offsets read 0.
- R3: While control bit0 (run, active high) and bit1 (count enable) are both 1, the counter advances by one every D clock cycles, where D is the divisor. A divisor of 0 or 1 gives one advance per cycle.
- R4: At 0xFFFFFFFF, a tick takes the counter to 0 when control bit2 (wrap) is 1, and leaves it at 0xFFFFFFFF when bit2 is 0.
- R5: Writing 1 to control bit3 (load request) makes the bit read 1 for two cycles and then 0. On the clock edge where it clears, the counter takes the preset value and the divisor phase restarts. Writing 0 to the bit does not cancel a pending request.
- R6: Writing 1 to control bit4 (snapshot request) makes the bit read 1 for two cycles and then 0. The snapshot registers then hold the counter value from the last cycle in which the bit read 1.
- R7: When a tick or a load gives the counter a value equal to the alarm value, the alarm flag (status bit0) is set and stays set. Status bit1 and the interrupt output equal the alarm flag AND NOT control bit5 (mask).
- R8: The mask hides the interrupt but leaves the alarm flag unchanged. Clearing the mask shows a pending alarm again.
- R9: Writing 1 to control bit6 sets the alarm flag. Writing 1 to control bit7 clears it, and clear wins when both are written together. Bits 6 and 7 always read 0.
- R10: While control bit0 is 0, the counter, the divisor phase and the alarm flag are held at 0. Divisor, preset, alarm value and control contents are kept, and request bits still complete.
- R11: With bit0 set and bit1 clear, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address; 0 when not selected |
| irq_o | output | 1 | Alarm interrupt, level |

## Verification
The hardest states to reach are the counter boundary at all ones and an alarm hit that lands on the very edge where the counter changes. Counting up to either one from reset is out of reach. The stimulus therefore uses the load handshake to preset the counter a few seconds short of the target, sets the divisor to 1 or 3 so each second lasts only a few cycles, and lets the bench model compare the interrupt on every cycle. The same preset path also produces an alarm hit caused by a load rather than by a tick.

// File: rtl/rtc_seconds_pkg.sv
// Package: shared widths, register offsets and control bit positions for
// the seconds counter clock. Assumes byte addressing with 16-bit registers.
package rtc_seconds_pkg;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 6;
    localparam int CNT_W  = 2 * REG_W;
    localparam int PAIRS  = 3;   // divisor, preset, alarm value

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_SNAPLO = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_SNAPHI = 6'h24;
    localparam int PAIR_BASE = 4;  // low half of the first pair
    localparam int PAIR_STEP = 8;

    localparam int B_RUN   = 0;
    localparam int B_CNTEN = 1;
    localparam int B_WRAP  = 2;
    localparam int B_LOAD  = 3;
    localparam int B_SNAP  = 4;
    localparam int B_MASK  = 5;
    localparam int B_FORCE = 6;
    localparam int B_CLEAR = 7;

    typedef struct packed {
        logic irq_mask;
        logic snap_req;
        logic load_req;
        logic wrap_en;
        logic cnt_en;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/rtc_seconds_regs.sv
// Register file: decodes the 16-bit register port, holds the control bits,
// the three 32-bit word pairs, and forms the read data. Request bits are set
// by software and cleared by the done strobes from the core. Force and clear
// become one-cycle pulses. Assumes a single-cycle access with no wait states.
module rtc_seconds_regs
    import rtc_seconds_pkg::*;
#(
    parameter int RW = REG_W,
    parameter int AW = ADDR_W,
    parameter int CW = CNT_W,
    parameter int NP = PAIRS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [RW-1:0] bus_wdata,
    output logic [RW-1:0] bus_rdata,
    output ctrl_t         ctrl_o,
    output logic          force_p_o,
    output logic          clear_p_o,
    output logic [CW-1:0] divisor_o,
    output logic [CW-1:0] preset_o,
    output logic [CW-1:0] alarm_val_o,
    input  logic          load_done_i,
    input  logic          snap_done_i,
    input  logic          alarm_i,
    input  logic [CW-1:0] snap_i
);
    logic                  wr_en, wr_ctrl;
    ctrl_t                 ctrl_q;
    logic                  force_q, clear_q;
    logic [NP-1:0][CW-1:0] pair_flat;

    assign wr_en   = bus_sel && bus_wr;
    assign wr_ctrl = wr_en && (bus_addr == OFS_CTRL);

    // Control register: level bits follow writes, requests are set and held until done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.run      <= bus_wdata[B_RUN];
                ctrl_q.cnt_en   <= bus_wdata[B_CNTEN];
                ctrl_q.wrap_en  <= bus_wdata[B_WRAP];
                ctrl_q.irq_mask <= bus_wdata[B_MASK];
            end
            ctrl_q.load_req <= (wr_ctrl && bus_wdata[B_LOAD]) || (ctrl_q.load_req && !load_done_i);
            ctrl_q.snap_req <= (wr_ctrl && bus_wdata[B_SNAP]) || (ctrl_q.snap_req && !snap_done_i);
        end
    end

    // Force and clear pulses: one cycle after the control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_q <= 1'b0;
            clear_q <= 1'b0;
        end else begin
            force_q <= wr_ctrl && bus_wdata[B_FORCE];
            clear_q <= wr_ctrl && bus_wdata[B_CLEAR];
        end
    end

    for (genvar gi = 0; gi < NP; gi++) begin : g_pair
        localparam logic [AW-1:0] LO_OFS = AW'(PAIR_BASE + PAIR_STEP * gi);
        localparam logic [AW-1:0] HI_OFS = AW'(PAIR_BASE + PAIR_STEP * gi + 4);
        logic [CW-1:0] word_q;

        // One 32-bit word written as two 16-bit halves.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_en && bus_addr == LO_OFS)
                word_q[RW-1:0] <= bus_wdata;
            else if (wr_en && bus_addr == HI_OFS)
                word_q[CW-1:RW] <= bus_wdata;
        end

        assign pair_flat[gi] = word_q;
    end

    // Read data mux: fixed registers first, then the word pairs.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            if (bus_addr == OFS_CTRL) begin
                bus_rdata[B_RUN]   = ctrl_q.run;
                bus_rdata[B_CNTEN] = ctrl_q.cnt_en;
                bus_rdata[B_WRAP]  = ctrl_q.wrap_en;
                bus_rdata[B_LOAD]  = ctrl_q.load_req;
                bus_rdata[B_SNAP]  = ctrl_q.snap_req;
                bus_rdata[B_MASK]  = ctrl_q.irq_mask;
            end
            if (bus_addr == OFS_STATUS) begin
                bus_rdata[0] = alarm_i;
                bus_rdata[1] = alarm_i && !ctrl_q.irq_mask;
            end
            if (bus_addr == OFS_SNAPLO) bus_rdata = snap_i[RW-1:0];
            if (bus_addr == OFS_SNAPHI) bus_rdata = snap_i[CW-1:RW];
            for (int i = 0; i < NP; i++) begin
                if (bus_addr == AW'(PAIR_BASE + PAIR_STEP * i))     bus_rdata = pair_flat[i][RW-1:0];
                if (bus_addr == AW'(PAIR_BASE + PAIR_STEP * i + 4)) bus_rdata = pair_flat[i][CW-1:RW];
            end
        end
    end

    assign ctrl_o      = ctrl_q;
    assign force_p_o   = force_q;
    assign clear_p_o   = clear_q;
    assign divisor_o   = pair_flat[0];
    assign preset_o    = pair_flat[1];
    assign alarm_val_o = pair_flat[2];

    // R5: a raised load request stays visible one more cycle, then drops.
    a_r5_load_req_life: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.load_req) |=> ctrl_q.load_req ##1 !ctrl_q.load_req);
    // R6: same life cycle for the snapshot request.
    a_r6_snap_req_life: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q.snap_req) |=> ctrl_q.snap_req ##1 !ctrl_q.snap_req);
    // R9: force and clear are single-cycle pulses when not rewritten.
    a_r9_force_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (force_q && !wr_ctrl) |=> !force_q);
endmodule

// File: rtl/rtc_seconds_prescale.sv
// Prescaler: counts reference cycles and emits one tick each time the
// divisor count is reached. Held at zero while the block is not running and
// restarted on a load. Assumes the divisor may change at any time; a
// lowered divisor simply ticks at the next cycle.
module rtc_seconds_prescale #(
    parameter int CW = rtc_seconds_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          cnt_en_i,
    input  logic          restart_i,
    input  logic [CW-1:0] divisor_i,
    output logic          tick_o
);
    logic [CW-1:0] phase_q;
    logic [CW:0]   phase_nx;

    assign phase_nx = {1'b0, phase_q} + 1'b1;
    assign tick_o   = run_i && cnt_en_i && !restart_i && (phase_nx >= {1'b0, divisor_i});

    // Phase counter: reset on stop or restart, wraps on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || restart_i)
            phase_q <= '0;
        else if (cnt_en_i)
            phase_q <= tick_o ? '0 : phase_nx[CW-1:0];
    end

    // R10: the phase is held at zero while not running.
    a_r10_phase_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> phase_q == '0);
endmodule

// File: rtl/rtc_seconds_core.sv
// Core: the seconds counter with wrap or saturate, the two-cycle load and
// snapshot handshakes, the alarm compare and the sticky alarm flag. Assumes
// the tick input is already qualified with run and count enable.
module rtc_seconds_core #(
    parameter int CW = rtc_seconds_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          cnt_en_i,
    input  logic          wrap_en_i,
    input  logic          load_req_i,
    input  logic          snap_req_i,
    input  logic          force_p_i,
    input  logic          clear_p_i,
    input  logic          tick_i,
    input  logic [CW-1:0] preset_i,
    input  logic [CW-1:0] alarm_val_i,
    output logic          load_fire_o,
    output logic          snap_fire_o,
    output logic          alarm_o,
    output logic [CW-1:0] snap_o
);
    logic          load_stage_q, snap_stage_q;
    logic [CW-1:0] count_q, count_nx, snap_q;
    logic          update, hit, alarm_q;

    // Handshake stages: each request is served on its second cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_stage_q <= 1'b0;
            snap_stage_q <= 1'b0;
        end else begin
            load_stage_q <= load_req_i && !load_stage_q;
            snap_stage_q <= snap_req_i && !snap_stage_q;
        end
    end

    assign load_fire_o = load_stage_q;
    assign snap_fire_o = snap_stage_q;

    // Next count: a load wins over a tick; the top value wraps or saturates.
    always_comb begin
        count_nx = count_q;
        update   = 1'b0;
        if (load_stage_q) begin
            count_nx = preset_i;
            update   = 1'b1;
        end else if (tick_i) begin
            update = 1'b1;
            if (&count_q)
                count_nx = wrap_en_i ? '0 : count_q;
            else
                count_nx = count_q + 1'b1;
        end
    end

    assign hit = update && (count_nx == alarm_val_i);

    // Counter register: held at zero while not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            count_q <= '0;
        else
            count_q <= count_nx;
    end

    // Alarm flag: clear beats force, force or hit sets, otherwise sticky.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            alarm_q <= 1'b0;
        else if (clear_p_i)
            alarm_q <= 1'b0;
        else if (force_p_i || hit)
            alarm_q <= 1'b1;
    end

    // Snapshot register: captures the live count when the request is served.
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= '0;
        else if (snap_stage_q)
            snap_q <= count_q;
    end

    assign alarm_o = alarm_q;
    assign snap_o  = snap_q;

    // R4: without wrap, the all-ones value is kept.
    a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !wrap_en_i && (&count_q) && !load_stage_q) |=> (&count_q));
    // R4: with wrap, a tick at all ones gives zero.
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && wrap_en_i && (&count_q) && tick_i && !load_stage_q) |=> count_q == '0);
    // R11: no count enable, no load: the count holds.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !cnt_en_i && !load_stage_q) |=> $stable(count_q));
    // R5: a served load puts the preset into the counter.
    a_r5_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && load_stage_q) |=> count_q == $past(preset_i));
    // R6: a served snapshot holds the count of the serving cycle.
    a_r6_snap_value: assert property (@(posedge clk) disable iff (!rst_n)
        snap_stage_q |=> snap_q == $past(count_q));
    // R9: clear drops the flag; force alone raises it.
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && clear_p_i) |=> !alarm_q);
    a_r9_force: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && force_p_i && !clear_p_i) |=> alarm_q);
    // R10: stopped block keeps counter and flag at zero.
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (count_q == '0) && !alarm_q);
endmodule

// File: rtl/rtc_seconds.sv
// Top: seconds counter clock with alarm. Joins the register file, the
// prescaler and the core, and drives the masked interrupt. Assumes one
// clock domain for the register port and the reference clock.
module rtc_seconds
    import rtc_seconds_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq_o
);
    ctrl_t             ctrl;
    logic              force_p, clear_p, tick, load_fire, snap_fire, alarm;
    logic [CNT_W-1:0]  divisor, preset, alarm_val, snap;

    rtc_seconds_regs #(.RW(REG_W), .AW(ADDR_W), .CW(CNT_W), .NP(PAIRS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctrl_o(ctrl), .force_p_o(force_p), .clear_p_o(clear_p),
        .divisor_o(divisor), .preset_o(preset), .alarm_val_o(alarm_val),
        .load_done_i(load_fire), .snap_done_i(snap_fire),
        .alarm_i(alarm), .snap_i(snap)
    );

    rtc_seconds_prescale #(.CW(CNT_W)) u_prescale (
        .clk(clk), .rst_n(rst_n),
        .run_i(ctrl.run), .cnt_en_i(ctrl.cnt_en), .restart_i(load_fire),
        .divisor_i(divisor), .tick_o(tick)
    );

    rtc_seconds_core #(.CW(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .run_i(ctrl.run), .cnt_en_i(ctrl.cnt_en), .wrap_en_i(ctrl.wrap_en),
        .load_req_i(ctrl.load_req), .snap_req_i(ctrl.snap_req),
        .force_p_i(force_p), .clear_p_i(clear_p), .tick_i(tick),
        .preset_i(preset), .alarm_val_i(alarm_val),
        .load_fire_o(load_fire), .snap_fire_o(snap_fire),
        .alarm_o(alarm), .snap_o(snap)
    );

    assign irq_o = alarm && !ctrl.irq_mask;

    // R8: a masked interrupt never shows while the flag is idle either way.
    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> alarm);
endmodule

// File: tb/rtc_seconds_tb_top.sv
// Bench: behavioural reference model stepped on every clock; register reads
// and the interrupt output are compared against it.
module rtc_seconds_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_o;

    int errors = 0, checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rtc_seconds dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    // Reference model state
    bit          m_run, m_en, m_wrap, m_mask, m_ld, m_sn, m_fp, m_cp, m_alarm;
    int          m_ld_age, m_sn_age;
    logic [31:0] m_div, m_pre, m_match, m_cnt, m_snap;
    longint      m_phase;

    always @(posedge clk) begin
        bit wc, lf, sf, hit;
        logic [31:0] nc;
        if (!rst_n) begin
            {m_run, m_en, m_wrap, m_mask, m_ld, m_sn, m_fp, m_cp, m_alarm} = '0;
            m_ld_age = 0; m_sn_age = 0; m_phase = 0;
            m_div = 0; m_pre = 0; m_match = 0; m_cnt = 0; m_snap = 0;
        end else begin
            wc = bus_sel && bus_wr && bus_addr == 6'h00;
            lf = m_ld && m_ld_age == 1;
            sf = m_sn && m_sn_age == 1;
            if (m_ld) m_ld_age = lf ? 0 : m_ld_age + 1;
            if (m_sn) m_sn_age = sf ? 0 : m_sn_age + 1;
            hit = 0; nc = m_cnt;
            if (m_run && lf) begin
                nc = m_pre; hit = (nc == m_match); m_phase = 0;
            end else if (m_run && m_en) begin
                if (m_phase + 1 >= longint'(m_div)) begin
                    m_phase = 0;
                    nc = (m_cnt == 32'hFFFF_FFFF) ? (m_wrap ? 32'h0 : m_cnt) : m_cnt + 1;
                    hit = (nc == m_match);
                end else m_phase = m_phase + 1;
            end
            if (sf) m_snap = m_cnt;
            if (!m_run) begin nc = 0; m_phase = 0; m_alarm = 0; end
            else if (m_cp) m_alarm = 0;
            else if (m_fp || hit) m_alarm = 1;
            m_cnt = nc;
            m_fp = wc && bus_wdata[6];
            m_cp = wc && bus_wdata[7];
            m_ld = (wc && bus_wdata[3]) || (m_ld && !lf);
            m_sn = (wc && bus_wdata[4]) || (m_sn && !sf);
            if (wc) begin
                m_run = bus_wdata[0]; m_en = bus_wdata[1];
                m_wrap = bus_wdata[2]; m_mask = bus_wdata[5];
            end
            if (bus_sel && bus_wr) case (bus_addr)
                6'h04: m_div[15:0] = bus_wdata;    6'h08: m_div[31:16] = bus_wdata;
                6'h0C: m_pre[15:0] = bus_wdata;    6'h10: m_pre[31:16] = bus_wdata;
                6'h14: m_match[15:0] = bus_wdata;  6'h18: m_match[31:16] = bus_wdata;
                default: ;
            endcase
        end
    end

    function automatic logic [15:0] m_read(logic [5:0] a);
        case (a)
            6'h00: return {10'b0, m_mask, m_sn, m_ld, m_wrap, m_en, m_run};
            6'h04: return m_div[15:0];   6'h08: return m_div[31:16];
            6'h0C: return m_pre[15:0];   6'h10: return m_pre[31:16];
            6'h14: return m_match[15:0]; 6'h18: return m_match[31:16];
            6'h1C: return {14'b0, m_alarm && !m_mask, m_alarm};
            6'h20: return m_snap[15:0];  6'h24: return m_snap[31:16];
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 check(bus_rdata, m_read(a), tag);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic snap_and_read(input logic [15:0] ctl, input string tag);
        wr(6'h00, ctl | 16'h0010);
        wait_cyc(3);
        rd(6'h20, tag);
        rd(6'h24, tag);
    endtask

    // R7: interrupt output compared with the model on every cycle.
    always @(negedge clk) begin
        if (rst_n && !finished) check({15'b0, irq_o}, {15'b0, m_alarm && !m_mask}, "R7 irq line");
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1;
        // R1: reset state of every register
        for (int a = 0; a <= 'h24; a += 4) rd(6'(a), "R1 reset value");
        // R2: map and read-back, plus an unmapped offset
        wr(6'h04, 16'd5);    wr(6'h08, 16'h0000);
        wr(6'h0C, 16'h1234); wr(6'h10, 16'h0056);
        wr(6'h14, 16'hFFFF); wr(6'h18, 16'hFFFF);
        for (int a = 4; a <= 'h18; a += 4) rd(6'(a), "R2 readback");
        rd(6'h28, "R2 unmapped");
        // R10: requests complete while stopped, counter stays zero
        wr(6'h00, 16'h0008);
        rd(6'h00, "R10 load req pending"); rd(6'h00, "R10 load req"); rd(6'h00, "R10 load req done");
        snap_and_read(16'h0000, "R10 stopped count");
        rd(6'h04, "R10 divisor kept");
        // R5: load while running
        wr(6'h00, 16'h0009);
        rd(6'h00, "R5 load bit high"); rd(6'h00, "R5 load bit cleared");
        rd(6'h00, "R5 load bit low");
        // R6: snapshot of the loaded value
        snap_and_read(16'h0001, "R6 snapshot after load");
        // R3: divisor 5, then 1, then 0
        wr(6'h00, 16'h0003);
        wait_cyc(23); snap_and_read(16'h0003, "R3 divisor 5");
        wait_cyc(7);  snap_and_read(16'h0003, "R3 divisor 5 again");
        wr(6'h04, 16'd1); wait_cyc(10); snap_and_read(16'h0003, "R3 divisor 1");
        wr(6'h04, 16'd0); wait_cyc(6);  snap_and_read(16'h0003, "R3 divisor 0");
        // R4: wrap at all ones
        wr(6'h00, 16'h0001); wr(6'h04, 16'd1);
        wr(6'h0C, 16'hFFFD); wr(6'h10, 16'hFFFF);
        wr(6'h00, 16'h0009); wait_cyc(3);
        wr(6'h00, 16'h0007); wait_cyc(5);
        snap_and_read(16'h0007, "R4 wrap to zero");
        // R4: saturate at all ones
        wr(6'h00, 16'h0009); wait_cyc(3);
        wr(6'h00, 16'h0003); wait_cyc(8);
        snap_and_read(16'h0003, "R4 saturate");
        // R11: hold with count enable clear
        wr(6'h00, 16'h0001);
        snap_and_read(16'h0001, "R11 hold first");
        wait_cyc(10);
        snap_and_read(16'h0001, "R11 hold second");
        // R7: alarm hit on a tick, divisor 3
        wr(6'h14, 16'h0020); wr(6'h18, 16'h0000);
        wr(6'h0C, 16'h001C); wr(6'h10, 16'h0000);
        wr(6'h04, 16'd3);
        wr(6'h00, 16'h0009); wait_cyc(3);
        rd(6'h1C, "R7 no alarm yet");
        wr(6'h00, 16'h0003); wait_cyc(20);
        rd(6'h1C, "R7 alarm on tick");
        // R8: mask hides the line but not the flag
        wr(6'h00, 16'h0023); rd(6'h1C, "R8 masked status");
        wr(6'h00, 16'h0003); rd(6'h1C, "R8 unmasked status");
        // R9: clear, force, both
        wr(6'h00, 16'h0083); wait_cyc(1); rd(6'h1C, "R9 cleared");
        rd(6'h00, "R9 pulse bits read zero");
        wr(6'h00, 16'h0043); wait_cyc(1); rd(6'h1C, "R9 forced");
        wr(6'h00, 16'h00C3); wait_cyc(1); rd(6'h1C, "R9 clear wins");
        // R7: alarm hit caused by a load
        wr(6'h0C, 16'h0020);
        wr(6'h00, 16'h000B); wait_cyc(3);
        rd(6'h1C, "R7 alarm on load");
        // R10: stop clears count and flag, keeps registers
        wr(6'h00, 16'h0002); wait_cyc(2);
        rd(6'h1C, "R10 flag cleared");
        rd(6'h04, "R10 divisor kept"); rd(6'h14, "R10 alarm value kept");
        rd(6'h00, "R10 control kept");
        snap_and_read(16'h0002, "R10 count zero");
        wait_cyc(2);
        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule